// File: doc/BRIEF.md
# Four-Quadrant CORDIC Phase Angle Unit

This block turns one in-phase/quadrature sample pair into a phase angle for the phase detector of a tan-lock style digital loop. Both signed components are taken in on the same clock edge as the start strobe. An iterative CORDIC in vectoring mode then drives the quadrature residue toward zero. The angle of each micro-rotation is added into an accumulator, and that sum is the result.

Vectors in the left half-plane are first folded into the right half-plane by a quarter-turn. The angle of that quarter-turn seeds the accumulator, so the result covers the whole circle. Angles are two's complement with full scale equal to π. A value of 2^(ANGLE_W-1) therefore stands for ±π, and angle sums wrap around the circle with no extra logic.

Each micro-rotation takes one clock cycle. At the default of eleven iterations, the result and a one-cycle done pulse appear eleven clock edges after the edge that accepted the start.

Top module: `cordic_atan`

## Requirements
- R1: In the done cycle, angle_o equals atan2(q, i) × 2^(ANGLE_W-1)/π within 32 LSB. This holds at the default widths, for any input whose larger component magnitude is at least 1024.
- R2: Inputs with a negative in-phase component, in both the second and the third quadrant, meet R1. The result sign follows the sign of the quadrature component.
- R3: The axis cases give these results within 32 LSB: (+a,0) gives 0, (0,+a) gives +2^(ANGLE_W-2), (0,−a) gives −2^(ANGLE_W-2), and (−a,0) gives ±π. The value ±π is compared modulo 2^ANGLE_W.
- R4: The input pair (0,0) gives angle_o exactly 0.
- R5: done_o goes high for exactly one cycle, ITERS clock edges after the edge that sampled start_i high while the block was idle. After reset, done_o is 0 and angle_o is 0.
- R6: A start_i that arrives while a computation is running is ignored. It neither restarts nor extends that computation, and it produces no extra done pulse.
- R7: Between done pulses, angle_o keeps its last result.
- R8: Only the input values present on the accepting edge are used. Changes to i_sample_i or q_sample_i after that edge have no effect on the result.
- R9: Full-scale inputs, including −2^(DATA_W-1) on either or both components, meet R1 without internal overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a computation when the block is idle |
| i_sample_i | input | DATA_W | In-phase component, signed |
| q_sample_i | input | DATA_W | Quadrature component, signed |
| angle_o | output | ANGLE_W | Phase angle, signed, full scale = π |
| done_o | output | 1 | One-cycle pulse marking a new angle_o |

## Verification
The bench targets the places where the folding logic can slip:
- A wrong quarter-turn direction in the left half-plane moves the result into the wrong quadrant or shifts it by π.
- The (0,0) input must come back as exactly zero. A design that lets that case run through the iterations returns about +π/2.
- Full-scale negative inputs would overflow a datapath that is too narrow, and the result would flip sign.
- Start strobes that arrive while busy must not restart the count. A design that restarts produces a late done or a second done pulse.
- The inputs are scrambled right after acceptance, so a design that keeps reading the live pins returns a wrong angle.

// File: rtl/cordic_atan_pkg.sv
package cordic_atan_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_RUN
  } ctrl_state_e;

  localparam int unsigned LUT_DEPTH = 16;

  // atan(2^-k) with pi = 2^31
  function automatic logic [31:0] atan_lut32(input int unsigned k);
    case (k)
      0:       return 32'd536870912;
      1:       return 32'd316933406;
      2:       return 32'd167458908;
      3:       return 32'd85004757;
      4:       return 32'd42667331;
      5:       return 32'd21354466;
      6:       return 32'd10679838;
      7:       return 32'd5340245;
      8:       return 32'd2670163;
      9:       return 32'd1335087;
      10:      return 32'd667544;
      11:      return 32'd333772;
      12:      return 32'd166886;
      13:      return 32'd83443;
      14:      return 32'd41722;
      15:      return 32'd20861;
      default: return 32'd0;
    endcase
  endfunction

  // rescale to pi = 2^(aw-1), rounded
  function automatic logic [63:0] atan_scaled(input int unsigned k, input int unsigned aw);
    logic [63:0] v;
    v = {32'd0, atan_lut32(k)} << aw;
    v = v + 64'h0000_0000_8000_0000;
    return v >> 32;
  endfunction

endpackage

// File: rtl/cordic_atan_prerot.sv
module cordic_atan_prerot #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned GUARD   = 2,
  parameter int unsigned XW      = 20,
  parameter int unsigned ANGLE_W = 16
) (
  input  logic signed [DATA_W-1:0]  i_i,
  input  logic signed [DATA_W-1:0]  q_i,
  output logic signed [XW-1:0]      x_o,
  output logic signed [XW-1:0]      y_o,
  output logic signed [ANGLE_W-1:0] z_o
);
  localparam logic signed [ANGLE_W-1:0] HALF_PI = ANGLE_W'(1) << (ANGLE_W - 2);

  logic signed [XW-1:0] ix, qx;

  assign ix = $signed({{(XW-DATA_W){i_i[DATA_W-1]}}, i_i}) <<< GUARD;
  assign qx = $signed({{(XW-DATA_W){q_i[DATA_W-1]}}, q_i}) <<< GUARD;

  always_comb begin
    x_o = ix;
    y_o = qx;
    z_o = '0;
    if (ix[XW-1]) begin
      if (!qx[XW-1]) begin
        x_o = qx;
        y_o = -ix;
        z_o = HALF_PI;
      end else begin
        x_o = -qx;
        y_o = ix;
        z_o = -HALF_PI;
      end
    end
  end

endmodule

// File: rtl/cordic_atan_stage.sv
module cordic_atan_stage #(
  parameter int unsigned XW      = 20,
  parameter int unsigned ANGLE_W = 16,
  parameter int unsigned SH_W    = 4
) (
  input  logic signed [XW-1:0]      x_i,
  input  logic signed [XW-1:0]      y_i,
  input  logic signed [ANGLE_W-1:0] z_i,
  input  logic        [SH_W-1:0]    shift_i,
  input  logic signed [ANGLE_W-1:0] step_ang_i,
  output logic signed [XW-1:0]      x_o,
  output logic signed [XW-1:0]      y_o,
  output logic signed [ANGLE_W-1:0] z_o
);
  logic signed [XW-1:0] xs, ys;

  assign xs = x_i >>> shift_i;
  assign ys = y_i >>> shift_i;

  // rotate toward y = 0
  always_comb begin
    if (!y_i[XW-1]) begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + step_ang_i;
    end else begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - step_ang_i;
    end
  end

endmodule

// File: rtl/cordic_atan_ctrl.sv
module cordic_atan_ctrl
  import cordic_atan_pkg::*;
#(
  parameter int unsigned ITERS = 11,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o,
  output logic [CNT_W-1:0] idx_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ITERS - 1);

  ctrl_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign last_o = step_o && (cnt_q == LAST_IDX);
  assign idx_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else if (last_o) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (step_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cordic_atan.sv
module cordic_atan
  import cordic_atan_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ANGLE_W = 16,
  parameter int unsigned ITERS   = 11,
  parameter int unsigned GUARD   = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic signed [DATA_W-1:0]  i_sample_i,
  input  logic signed [DATA_W-1:0]  q_sample_i,
  output logic signed [ANGLE_W-1:0] angle_o,
  output logic                      done_o
);
  // 2 bits headroom: quarter-turn of -2^(N-1) and CORDIC gain
  localparam int unsigned XW    = DATA_W + 2 + GUARD;
  localparam int unsigned CNT_W = $clog2(ITERS + 1);

  logic                      load, step, last;
  logic [CNT_W-1:0]          idx;
  logic signed [XW-1:0]      pre_x, pre_y, x_q, y_q, nx_x, nx_y;
  logic signed [ANGLE_W-1:0] pre_z, z_q, nx_z, step_ang;
  logic [63:0]               ang_full;
  logic                      zero_q;
  logic signed [ANGLE_W-1:0] angle_q;
  logic                      done_q;

  cordic_atan_ctrl #(
    .ITERS(ITERS),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .last_o (last),
    .idx_o  (idx)
  );

  cordic_atan_prerot #(
    .DATA_W (DATA_W),
    .GUARD  (GUARD),
    .XW     (XW),
    .ANGLE_W(ANGLE_W)
  ) u_prerot (
    .i_i(i_sample_i),
    .q_i(q_sample_i),
    .x_o(pre_x),
    .y_o(pre_y),
    .z_o(pre_z)
  );

  assign ang_full = atan_scaled(int'(idx), ANGLE_W);
  assign step_ang = ang_full[ANGLE_W-1:0];

  cordic_atan_stage #(
    .XW     (XW),
    .ANGLE_W(ANGLE_W),
    .SH_W   (CNT_W)
  ) u_stage (
    .x_i       (x_q),
    .y_i       (y_q),
    .z_i       (z_q),
    .shift_i   (idx),
    .step_ang_i(step_ang),
    .x_o       (nx_x),
    .y_o       (nx_y),
    .z_o       (nx_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      zero_q <= 1'b0;
    end else if (load) begin
      x_q    <= pre_x;
      y_q    <= pre_y;
      z_q    <= pre_z;
      zero_q <= (i_sample_i == '0) && (q_sample_i == '0);
    end else if (step) begin
      x_q <= nx_x;
      y_q <= nx_y;
      z_q <= nx_z;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      angle_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (last) angle_q <= zero_q ? '0 : nx_z;
    end
  end

  assign angle_o = angle_q;
  assign done_o  = done_q;

endmodule

// File: rtl/cordic_atan_chk.sv
module cordic_atan_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ANGLE_W = 16,
  parameter int unsigned ITERS   = 11
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      start_i,
  input logic signed [DATA_W-1:0]  i_sample_i,
  input logic signed [DATA_W-1:0]  q_sample_i,
  input logic signed [ANGLE_W-1:0] angle_o,
  input logic                      done_o
);
  localparam int unsigned CW = $clog2(ITERS + 2);
  localparam logic [CW-1:0] END_CNT = CW'(ITERS);

  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] cap_i_q, cap_q_q;

  // independent cycle count since acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      cap_i_q <= '0;
      cap_q_q <= '0;
    end else if (cnt_q == '0) begin
      if (start_i) begin
        cnt_q   <= CW'(1);
        cap_i_q <= i_sample_i;
        cap_q_q <= q_sample_i;
      end
    end else if (cnt_q == END_CNT) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == END_CNT) |=> done_o);

  // R6
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(cnt_q) == END_CNT));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  angle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(angle_o));

  // R4
  zero_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cap_i_q == '0 && cap_q_q == '0) |-> (angle_o == '0));

endmodule

bind cordic_atan cordic_atan_chk #(
  .DATA_W (DATA_W),
  .ANGLE_W(ANGLE_W),
  .ITERS  (ITERS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .i_sample_i(i_sample_i),
  .q_sample_i(q_sample_i),
  .angle_o   (angle_o),
  .done_o    (done_o)
);

// File: tb/cordic_atan_tb.sv
`timescale 1ns/1ps
module cordic_atan_tb;
  localparam int ITERS = 11;
  localparam int TOL   = 32;
  localparam real PI   = 3.14159265358979;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic signed [15:0] i_s = '0;
  logic signed [15:0] q_s = '0;
  logic signed [15:0] angle;
  logic               done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cordic_atan #(.DATA_W(16), .ANGLE_W(16), .ITERS(ITERS), .GUARD(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .i_sample_i(i_s), .q_sample_i(q_s),
    .angle_o(angle), .done_o(done)
  );

  function automatic logic signed [15:0] exp_angle(input int ii, input int qq);
    real r;
    if (ii == 0 && qq == 0) return '0;
    r = $atan2(real'(qq), real'(ii)) / PI * 32768.0;
    return 16'($rtoi(r + ((r >= 0.0) ? 0.5 : -0.5)));
  endfunction

  task automatic check_int(input string req, input int got, input int expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic check_ang(input string req, input logic signed [15:0] got,
                           input logic signed [15:0] expv);
    logic signed [15:0] d;
    d = got - expv;
    checks++;
    if (d > TOL || d < -TOL) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  // start at one edge, scramble inputs afterwards
  task automatic run_op(input logic signed [15:0] ii, input logic signed [15:0] qq,
                        output logic signed [15:0] ang, output int lat);
    @(negedge clk);
    i_s = ii; q_s = qq; start = 1'b1;
    @(negedge clk);
    start = 1'b0; i_s = ~ii; q_s = 16'sh5a5a;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    ang = angle;
  endtask

  task automatic t_reset();
    check_int("R5 reset done", int'(done), 0);
    check_int("R5 reset angle", int'(angle), 0);
  endtask

  task automatic t_quadrants();
    int vi[6] = '{20000, -12000, -25000, 9000, 30000, -1500};
    int vq[6] = '{7000, 15000, -3000, -30000, 30000, 1200};
    logic signed [15:0] a;
    int lat;
    for (int k = 0; k < 6; k++) begin
      run_op(16'(vi[k]), 16'(vq[k]), a, lat);
      if (vi[k] < 0) check_ang("R2 left half-plane", a, exp_angle(vi[k], vq[k]));
      else           check_ang("R1 right half-plane", a, exp_angle(vi[k], vq[k]));
    end
  endtask

  task automatic t_axes();
    logic signed [15:0] a;
    int lat;
    run_op(16'sd20000, 16'sd0, a, lat);  check_ang("R3 +i axis", a, 16'sd0);
    run_op(16'sd0, 16'sd20000, a, lat);  check_ang("R3 +q axis", a, 16'sd16384);
    run_op(16'sd0, -16'sd20000, a, lat); check_ang("R3 -q axis", a, -16'sd16384);
    run_op(-16'sd20000, 16'sd0, a, lat); check_ang("R3 -i axis", a, -16'sd32768);
  endtask

  task automatic t_zero();
    logic signed [15:0] a;
    int lat;
    run_op(16'sd0, 16'sd0, a, lat);
    check_int("R4 zero input", int'(a), 0);
  endtask

  task automatic t_latency();
    logic signed [15:0] a;
    int lat;
    run_op(16'sd5000, 16'sd5000, a, lat);
    // done seen after edge ITERS past the accepting edge
    check_int("R5 latency", lat, ITERS + 1);
    @(negedge clk);
    check_int("R5 one-cycle done", int'(done), 0);
  endtask

  task automatic t_busy_start();
    int lat = 1;
    int extra = 0;
    @(negedge clk);
    i_s = 16'sd10000; q_s = 16'sd20000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      lat++;
      start = 1'b1; i_s = -16'sd30000; q_s = -16'sd100;
    end
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check_int("R6 busy start latency", lat, ITERS + 1);
    check_ang("R6 busy start result", angle, exp_angle(10000, 20000));
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check_int("R6 no extra done", extra, 0);
  endtask

  task automatic t_hold();
    logic signed [15:0] a;
    int lat;
    int moved = 0;
    run_op(-16'sd8000, 16'sd3000, a, lat);
    i_s = 16'sd123; q_s = -16'sd4567;
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      if (angle !== a || done) moved++;
    end
    check_int("R7 angle hold", moved, 0);
  endtask

  task automatic t_sample();
    logic signed [15:0] a;
    int lat;
    // run_op changes the inputs right after acceptance
    run_op(16'sd2000, -16'sd18000, a, lat);
    check_ang("R8 sampled inputs", a, exp_angle(2000, -18000));
  endtask

  task automatic t_extreme();
    logic signed [15:0] a;
    int lat;
    run_op(-16'sd32768, -16'sd32768, a, lat);
    check_ang("R9 full-scale third quadrant", a, exp_angle(-32768, -32768));
    run_op(16'sd32767, -16'sd32768, a, lat);
    check_ang("R9 full-scale fourth quadrant", a, exp_angle(32767, -32768));
    run_op(-16'sd32768, 16'sd32767, a, lat);
    check_ang("R9 full-scale second quadrant", a, exp_angle(-32768, 32767));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_quadrants();
    t_axes();
    t_zero();
    t_latency();
    t_busy_start();
    t_hold();
    t_sample();
    t_extreme();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule